// File: doc/BRIEF.md
# Register Reservation Issue Interlock

This block sits beside the current-instruction holding register of an in-order issue stage and decides, every cycle, whether the decoded instruction waiting there may issue. It keeps one reservation bit for each address and scalar register that has a result pending, a whole-register reservation with a countdown for each vector register in use, and one arrival-slot map per address and scalar file. The slot maps predict the cycles in which results will land on each file's single write port.

The decoder presents the instruction as source masks for the three files, a destination class and index, the unit latency and the vector length. The datapath reports address and scalar result writes, and a per-register strobe that marks a vector element being written in the current cycle. The block answers with a combinational grant. When the grant uses a vector register whose incoming element is being delivered that cycle, it also raises a forwarding enable for that register, so the element can be fed straight into the next unit.

Top module: `issue_interlock`

## Requirements
- R1: After reset no register is reserved and no arrival slot is taken. Grant is low whenever the instruction-valid input is low, and reset clears any reservation made before it.
- R2: Issuing an instruction that writes an address register (destination class 1) reserves that register. Any later instruction that reads or writes it is refused. The reservation is released by the clock edge at the end of the cycle in which the address write strobe names that register.
- R3: Scalar registers (destination class 2) are reserved and released in the same way through the scalar write strobe. Address and scalar reservations do not affect each other.
- R4: A result with latency L issued in cycle t lands on its file's write port in cycle t+L. An address-writing instruction is refused if its result would land in the same cycle as an earlier address result. A different landing cycle is accepted.
- R5: Scalar results obey the same one-per-cycle landing rule. Landings on the address port never block scalar results, and landings on the scalar port never block address results.
- R6: A vector instruction (destination class 3) reserves its whole destination vector register for vecLen+latency cycles after the issue edge, using the length and latency sampled at issue.
- R7: The source vector registers of a vector instruction are reserved for the same interval as its destination.
- R8: A scalar source of a vector instruction is not reserved, so a later scalar write to it may issue at once. A change on the vector-length input after issue does not move the release cycle.
- R9: A reserved vector register may be used as a source only when it is the pending destination of an earlier vector instruction and its delivery strobe is high in that cycle. A register reserved as a source cannot be used this way.
- R10: A forwarding-enable bit is high only in a granted cycle, and only for a source vector register that was used through that same-cycle delivery. Otherwise all forwarding enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | A decoded instruction is waiting to issue |
| srcAMask | input | NUM_A | Address registers read by the instruction |
| srcSMask | input | NUM_S | Scalar registers read by the instruction |
| srcVMask | input | NUM_V | Vector registers read by the instruction |
| dstKind | input | 2 | Destination class: 0 none, 1 address, 2 scalar, 3 vector |
| dstIdx | input | IDX_W | Destination register index |
| latency | input | LAT_W | Unit latency in cycles (at least 1 for address/scalar results) |
| vecLen | input | VL_W | Vector length for a vector instruction |
| aWrValid | input | 1 | An address result is written this cycle |
| aWrIdx | input | AIDX_W | Address register being written |
| sWrValid | input | 1 | A scalar result is written this cycle |
| sWrIdx | input | SIDX_W | Scalar register being written |
| vDeliver | input | NUM_V | Per vector register: an element is being written this cycle |
| issueGrant | output | 1 | The waiting instruction issues at the coming edge |
| chainFwd | output | NUM_V | Route the element being delivered to this register into the issuing unit |

## Verification
The assertions check every cycle that each address or scalar write strobe names a reserved register and matches an occupied landing slot. They also check that a vector register only becomes busy after a vector issue, that forwarding enables follow the delivery strobes, and that a reservation strobe never appears without a grant. Only the directed scenarios can show the exact release cycle of a vector reservation and that a later change of vector length leaves it in place. The same holds for the refusal of a colliding landing cycle next to acceptance of a neighbouring one, for the freedom of a vector instruction's scalar source, and for the refusal to forward from a register that is being read.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_A    = 2'd1,
    DST_S    = 2'd2,
    DST_V    = 2'd3
  } dstKind_e;

  // strobes from the issue control to the reservation state
  typedef struct packed {
    logic grant;
    logic rsvA;
    logic rsvS;
    logic rsvV;
  } issueStrobe_t;

endpackage

// File: rtl/resv_state.sv
module resv_state
  import resv_pkg::*;
#(
  parameter int NUM_A   = 8,
  parameter int NUM_S   = 8,
  parameter int NUM_V   = 8,
  parameter int MAX_LAT = 15,
  parameter int VL_W    = 7,
  parameter int IDX_W   = 3,
  parameter int LAT_W   = 4,
  parameter int AIDX_W  = 3,
  parameter int SIDX_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  issueStrobe_t       strobe,
  input  logic [NUM_V-1:0]   srcVMask,
  input  logic [IDX_W-1:0]   dstIdx,
  input  logic [LAT_W-1:0]   latency,
  input  logic [VL_W-1:0]    vecLen,
  input  logic               aWrValid,
  input  logic [AIDX_W-1:0]  aWrIdx,
  input  logic               sWrValid,
  input  logic [SIDX_W-1:0]  sWrIdx,
  output logic [NUM_A-1:0]   aResQ,
  output logic [NUM_S-1:0]   sResQ,
  output logic [MAX_LAT:0]   aSlotQ,
  output logic [MAX_LAT:0]   sSlotQ,
  output logic [NUM_V-1:0]   vBusyQ,
  output logic [NUM_V-1:0]   vIsDstQ
);

  localparam int VIDX_W = $clog2(NUM_V);
  localparam int CNT_W  = $clog2((1 << VL_W) + MAX_LAT + 1);

  logic [NUM_A-1:0] aResD;
  logic [NUM_S-1:0] sResD;
  logic [MAX_LAT:0] aSlotD;
  logic [MAX_LAT:0] sSlotD;
  logic [CNT_W-1:0] holdLen;

  assign holdLen = CNT_W'(vecLen) + CNT_W'(latency);

  // address and scalar reservations plus landing-slot maps
  always_comb begin
    aResD = aResQ;
    sResD = sResQ;
    if (aWrValid) aResD[aWrIdx] = 1'b0;
    if (sWrValid) sResD[sWrIdx] = 1'b0;
    if (strobe.rsvA) aResD[dstIdx[AIDX_W-1:0]] = 1'b1;
    if (strobe.rsvS) sResD[dstIdx[SIDX_W-1:0]] = 1'b1;
    aSlotD = aSlotQ >> 1;
    sSlotD = sSlotQ >> 1;
    if (strobe.rsvA) aSlotD[latency - 1'b1] = 1'b1;
    if (strobe.rsvS) sSlotD[latency - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aResQ  <= '0;
      sResQ  <= '0;
      aSlotQ <= '0;
      sSlotQ <= '0;
    end else begin
      aResQ  <= aResD;
      sResQ  <= sResD;
      aSlotQ <= aSlotD;
      sSlotQ <= sSlotD;
    end
  end

  // whole-register vector reservations, one countdown each
  for (genvar g = 0; g < NUM_V; g++) begin : gVreg
    logic [CNT_W-1:0] cntQ;
    logic             dstQ;
    logic             takeSrc;
    logic             takeDst;

    assign takeSrc = strobe.rsvV && srcVMask[g];
    assign takeDst = strobe.rsvV && (dstIdx[VIDX_W-1:0] == VIDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
        dstQ <= 1'b0;
      end else if (takeSrc || takeDst) begin
        cntQ <= (holdLen > cntQ) ? holdLen : cntQ;
        dstQ <= takeDst && !takeSrc;
      end else if (cntQ != '0) begin
        cntQ <= cntQ - 1'b1;
        if (cntQ == CNT_W'(1)) dstQ <= 1'b0;
      end
    end

    assign vBusyQ[g]  = (cntQ != '0);
    assign vIsDstQ[g] = dstQ;

    AST_V_BUSY_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(vBusyQ[g]) |-> $past(strobe.rsvV)); // R6
  end

  AST_A_WRITE_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    aWrValid |-> aResQ[aWrIdx]); // R2
  AST_S_WRITE_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    sWrValid |-> sResQ[sWrIdx]); // R3
  AST_A_LANDING_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    aWrValid |-> aSlotQ[0]); // R4
  AST_S_LANDING_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    sWrValid |-> sSlotQ[0]); // R5
  AST_RSV_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rsvA || strobe.rsvS || strobe.rsvV) |-> strobe.grant); // R1

endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import resv_pkg::*;
#(
  parameter int NUM_A   = 8,
  parameter int NUM_S   = 8,
  parameter int NUM_V   = 8,
  parameter int MAX_LAT = 15,
  parameter int IDX_W   = 3,
  parameter int LAT_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [NUM_A-1:0]   srcAMask,
  input  logic [NUM_S-1:0]   srcSMask,
  input  logic [NUM_V-1:0]   srcVMask,
  input  logic [1:0]         dstKind,
  input  logic [IDX_W-1:0]   dstIdx,
  input  logic [LAT_W-1:0]   latency,
  input  logic [NUM_V-1:0]   vDeliver,
  input  logic [NUM_A-1:0]   aResQ,
  input  logic [NUM_S-1:0]   sResQ,
  input  logic [MAX_LAT:0]   aSlotQ,
  input  logic [MAX_LAT:0]   sSlotQ,
  input  logic [NUM_V-1:0]   vBusyQ,
  input  logic [NUM_V-1:0]   vIsDstQ,
  output issueStrobe_t       strobe,
  output logic [NUM_V-1:0]   chainFwd
);

  localparam int AIDX_W = $clog2(NUM_A);
  localparam int SIDX_W = $clog2(NUM_S);
  localparam int VIDX_W = $clog2(NUM_V);

  dstKind_e         kind;
  logic [NUM_V-1:0] vReady;
  logic             srcOk;
  logic             dstOk;
  logic             grant;

  assign kind = dstKind_e'(dstKind);

  // a busy vector source is usable only via same-cycle delivery
  assign vReady = ~vBusyQ | (vIsDstQ & vDeliver);

  assign srcOk = ((srcAMask & aResQ) == '0) &&
                 ((srcSMask & sResQ) == '0) &&
                 ((srcVMask & ~vReady) == '0);

  always_comb begin
    case (kind)
      DST_A:   dstOk = !aResQ[dstIdx[AIDX_W-1:0]] && !aSlotQ[latency];
      DST_S:   dstOk = !sResQ[dstIdx[SIDX_W-1:0]] && !sSlotQ[latency];
      DST_V:   dstOk = !vBusyQ[dstIdx[VIDX_W-1:0]];
      default: dstOk = 1'b1;
    endcase
  end

  assign grant = instValid && srcOk && dstOk;

  always_comb begin
    strobe.grant = grant;
    strobe.rsvA  = grant && (kind == DST_A);
    strobe.rsvS  = grant && (kind == DST_S);
    strobe.rsvV  = grant && (kind == DST_V);
  end

  assign chainFwd = grant ? (srcVMask & vBusyQ) : '0;

  AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rsvA || strobe.rsvS) |-> (latency != '0)); // R4
  AST_CHAIN_ON_DELIVERY: assert property (@(posedge clk) disable iff (!rstN)
    ((chainFwd & ~vDeliver) == '0)); // R9
  AST_CHAIN_IN_SOURCES: assert property (@(posedge clk) disable iff (!rstN)
    ((chainFwd & ~srcVMask) == '0)); // R10

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import resv_pkg::*;
#(
  parameter int NUM_A   = 8,
  parameter int NUM_S   = 8,
  parameter int NUM_V   = 8,
  parameter int MAX_LAT = 15,
  parameter int VL_W    = 7,
  parameter int IDX_W   = $clog2((NUM_A > NUM_S) ? ((NUM_A > NUM_V) ? NUM_A : NUM_V)
                                                 : ((NUM_S > NUM_V) ? NUM_S : NUM_V)),
  parameter int LAT_W   = $clog2(MAX_LAT + 1),
  parameter int AIDX_W  = $clog2(NUM_A),
  parameter int SIDX_W  = $clog2(NUM_S)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [NUM_A-1:0]   srcAMask,
  input  logic [NUM_S-1:0]   srcSMask,
  input  logic [NUM_V-1:0]   srcVMask,
  input  logic [1:0]         dstKind,
  input  logic [IDX_W-1:0]   dstIdx,
  input  logic [LAT_W-1:0]   latency,
  input  logic [VL_W-1:0]    vecLen,
  input  logic               aWrValid,
  input  logic [AIDX_W-1:0]  aWrIdx,
  input  logic               sWrValid,
  input  logic [SIDX_W-1:0]  sWrIdx,
  input  logic [NUM_V-1:0]   vDeliver,
  output logic               issueGrant,
  output logic [NUM_V-1:0]   chainFwd
);

  issueStrobe_t     strobe;
  logic [NUM_A-1:0] aResQ;
  logic [NUM_S-1:0] sResQ;
  logic [MAX_LAT:0] aSlotQ;
  logic [MAX_LAT:0] sSlotQ;
  logic [NUM_V-1:0] vBusyQ;
  logic [NUM_V-1:0] vIsDstQ;

  issue_ctrl #(
    .NUM_A(NUM_A), .NUM_S(NUM_S), .NUM_V(NUM_V),
    .MAX_LAT(MAX_LAT), .IDX_W(IDX_W), .LAT_W(LAT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .instValid(instValid),
    .srcAMask(srcAMask), .srcSMask(srcSMask), .srcVMask(srcVMask),
    .dstKind(dstKind), .dstIdx(dstIdx), .latency(latency),
    .vDeliver(vDeliver), .aResQ(aResQ), .sResQ(sResQ),
    .aSlotQ(aSlotQ), .sSlotQ(sSlotQ), .vBusyQ(vBusyQ), .vIsDstQ(vIsDstQ),
    .strobe(strobe), .chainFwd(chainFwd)
  );

  resv_state #(
    .NUM_A(NUM_A), .NUM_S(NUM_S), .NUM_V(NUM_V), .MAX_LAT(MAX_LAT),
    .VL_W(VL_W), .IDX_W(IDX_W), .LAT_W(LAT_W),
    .AIDX_W(AIDX_W), .SIDX_W(SIDX_W)
  ) state_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcVMask(srcVMask), .dstIdx(dstIdx), .latency(latency), .vecLen(vecLen),
    .aWrValid(aWrValid), .aWrIdx(aWrIdx), .sWrValid(sWrValid), .sWrIdx(sWrIdx),
    .aResQ(aResQ), .sResQ(sResQ), .aSlotQ(aSlotQ), .sSlotQ(sSlotQ),
    .vBusyQ(vBusyQ), .vIsDstQ(vIsDstQ)
  );

  assign issueGrant = strobe.grant;

endmodule

// File: tb/issue_interlock_tb.sv
module issue_interlock_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instValid;
  logic [7:0] srcAMask, srcSMask, srcVMask;
  logic [1:0] dstKind;
  logic [2:0] dstIdx;
  logic [3:0] latency;
  logic [6:0] vecLen;
  logic       aWrValid, sWrValid;
  logic [2:0] aWrIdx, sWrIdx;
  logic [7:0] vDeliver;
  logic       issueGrant;
  logic [7:0] chainFwd;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  issue_interlock dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid),
    .srcAMask(srcAMask), .srcSMask(srcSMask), .srcVMask(srcVMask),
    .dstKind(dstKind), .dstIdx(dstIdx), .latency(latency), .vecLen(vecLen),
    .aWrValid(aWrValid), .aWrIdx(aWrIdx), .sWrValid(sWrValid), .sWrIdx(sWrIdx),
    .vDeliver(vDeliver), .issueGrant(issueGrant), .chainFwd(chainFwd)
  );

  task automatic idle();
    instValid = 1'b0; srcAMask = '0; srcSMask = '0; srcVMask = '0;
    dstKind = 2'd0; dstIdx = '0; latency = 4'd1;
    aWrValid = 1'b0; aWrIdx = '0; sWrValid = 1'b0; sWrIdx = '0; vDeliver = '0;
  endtask

  task automatic drive(input logic [7:0] aM, input logic [7:0] sM, input logic [7:0] vM,
                       input logic [1:0] kind, input logic [2:0] idx,
                       input logic [3:0] lat, input logic [6:0] vl);
    instValid = 1'b1; srcAMask = aM; srcSMask = sM; srcVMask = vM;
    dstKind = kind; dstIdx = idx; latency = lat; vecLen = vl;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // check combinational outputs mid-cycle, then move to the next cycle
  task automatic probe(input logic expG, input logic [7:0] expC, input string tag);
    #1;
    check({tag, " grant"}, 32'(issueGrant), 32'(expG));
    check({tag, " chain"}, 32'(chainFwd), 32'(expC));
    @(negedge clk);
    idle();
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0; idle(); vecLen = 7'd4;
    wait_cycles(2);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    probe(1'b0, 8'h00, "R1 idle after reset");
    drive(8'hFF, 8'hFF, 8'hFF, 2'd1, 3'd0, 4'd1, 7'd4);
    probe(1'b1, 8'h00, "R1 all sources free after reset");
  endtask

  task automatic t_addr_resv();
    do_reset();
    drive(8'h00, 8'h00, 8'h00, 2'd1, 3'd3, 4'd4, 7'd4);
    probe(1'b1, 8'h00, "R2 issue A3 write");
    drive(8'h08, 8'h00, 8'h00, 2'd0, 3'd0, 4'd1, 7'd4);
    probe(1'b0, 8'h00, "R2 read of reserved A3");
    drive(8'h00, 8'h00, 8'h00, 2'd1, 3'd3, 4'd2, 7'd4);
    probe(1'b0, 8'h00, "R2 rewrite of reserved A3");
    drive(8'h04, 8'h00, 8'h00, 2'd0, 3'd0, 4'd1, 7'd4);
    probe(1'b1, 8'h00, "R2 read of free A2");
    drive(8'h08, 8'h00, 8'h00, 2'd0, 3'd0, 4'd1, 7'd4);
    aWrValid = 1'b1; aWrIdx = 3'd3;
    probe(1'b0, 8'h00, "R2 blocked in write cycle");
    drive(8'h08, 8'h00, 8'h00, 2'd0, 3'd0, 4'd1, 7'd4);
    probe(1'b1, 8'h00, "R2 free after write");
  endtask

  task automatic t_scal_resv();
    do_reset();
    drive(8'h00, 8'h00, 8'h00, 2'd2, 3'd6, 4'd3, 7'd4);
    probe(1'b1, 8'h00, "R3 issue S6 write");
    drive(8'h00, 8'h40, 8'h00, 2'd0, 3'd0, 4'd1, 7'd4);
    probe(1'b0, 8'h00, "R3 read of reserved S6");
    drive(8'h00, 8'h00, 8'h00, 2'd1, 3'd6, 4'd1, 7'd4);
    probe(1'b1, 8'h00, "R3 A6 unaffected by S6");
    drive(8'h00, 8'h40, 8'h00, 2'd0, 3'd0, 4'd1, 7'd4);
    sWrValid = 1'b1; sWrIdx = 3'd6;
    probe(1'b0, 8'h00, "R3 blocked in write cycle");
    drive(8'h00, 8'h40, 8'h00, 2'd0, 3'd0, 4'd1, 7'd4);
    probe(1'b1, 8'h00, "R3 free after write");
  endtask

  task automatic t_addr_port();
    do_reset();
    drive(8'h00, 8'h00, 8'h00, 2'd1, 3'd1, 4'd5, 7'd4);
    probe(1'b1, 8'h00, "R4 issue lands cycle 5");
    drive(8'h00, 8'h00, 8'h00, 2'd1, 3'd2, 4'd4, 7'd4);
    probe(1'b0, 8'h00, "R4 cycle1 lat4 collides");
    drive(8'h00, 8'h00, 8'h00, 2'd1, 3'd2, 4'd3, 7'd4);
    probe(1'b0, 8'h00, "R4 cycle2 lat3 collides");
    drive(8'h00, 8'h00, 8'h00, 2'd1, 3'd2, 4'd3, 7'd4);
    probe(1'b1, 8'h00, "R4 cycle3 lat3 lands 6");
    drive(8'h00, 8'h00, 8'h00, 2'd1, 3'd4, 4'd2, 7'd4);
    probe(1'b0, 8'h00, "R4 cycle4 lat2 collides at 6");
    drive(8'h00, 8'h00, 8'h00, 2'd2, 3'd2, 4'd1, 7'd4);
    probe(1'b1, 8'h00, "R5 scalar lands 6 beside address");
  endtask

  task automatic t_scal_port();
    do_reset();
    drive(8'h00, 8'h00, 8'h00, 2'd2, 3'd0, 4'd6, 7'd4);
    probe(1'b1, 8'h00, "R5 issue lands cycle 6");
    wait_cycles(1);
    drive(8'h00, 8'h00, 8'h00, 2'd2, 3'd1, 4'd4, 7'd4);
    probe(1'b0, 8'h00, "R5 cycle2 lat4 collides");
    drive(8'h00, 8'h00, 8'h00, 2'd1, 3'd5, 4'd3, 7'd4);
    probe(1'b1, 8'h00, "R5 address lands 6 beside scalar");
    drive(8'h00, 8'h00, 8'h00, 2'd2, 3'd1, 4'd4, 7'd4);
    probe(1'b1, 8'h00, "R5 cycle4 lat4 lands 8");
  endtask

  task automatic t_vector();
    do_reset();
    drive(8'h00, 8'h20, 8'h03, 2'd3, 3'd2, 4'd3, 7'd4);
    probe(1'b1, 8'h00, "R6 vector issue hold 7");
    drive(8'h00, 8'h00, 8'h00, 2'd2, 3'd5, 4'd1, 7'd60);
    probe(1'b1, 8'h00, "R8 scalar source not reserved");
    drive(8'h00, 8'h00, 8'h01, 2'd3, 3'd5, 4'd2, 7'd60);
    probe(1'b0, 8'h00, "R7 operand V0 reserved");
    drive(8'h00, 8'h00, 8'h00, 2'd3, 3'd1, 4'd2, 7'd60);
    probe(1'b0, 8'h00, "R7 operand V1 reserved");
    drive(8'h00, 8'h00, 8'h00, 2'd3, 3'd2, 4'd2, 7'd60);
    probe(1'b0, 8'h00, "R6 result V2 reserved");
    wait_cycles(2);
    drive(8'h00, 8'h00, 8'h05, 2'd3, 3'd3, 4'd2, 7'd60);
    probe(1'b0, 8'h00, "R6 last reserved cycle");
    drive(8'h00, 8'h00, 8'h07, 2'd3, 3'd3, 4'd2, 7'd60);
    probe(1'b1, 8'h00, "R8 release fixed at issue length");
  endtask

  task automatic t_chain();
    do_reset();
    drive(8'h00, 8'h00, 8'h40, 2'd3, 3'd4, 4'd2, 7'd8);
    probe(1'b1, 8'h00, "R9 producer to V4");
    drive(8'h00, 8'h00, 8'h10, 2'd3, 3'd5, 4'd2, 7'd8);
    probe(1'b0, 8'h00, "R10 no delivery no chain");
    drive(8'h00, 8'h00, 8'h10, 2'd3, 3'd5, 4'd2, 7'd8);
    vDeliver = 8'h10;
    probe(1'b1, 8'h10, "R9 chain from V4");
    drive(8'h00, 8'h00, 8'h10, 2'd3, 3'd7, 4'd2, 7'd8);
    vDeliver = 8'h10;
    probe(1'b0, 8'h00, "R9 V4 now read-reserved");
    drive(8'h00, 8'h00, 8'h40, 2'd3, 3'd7, 4'd2, 7'd8);
    vDeliver = 8'h40;
    probe(1'b0, 8'h00, "R9 operand V6 not chainable");
    drive(8'h00, 8'h00, 8'h20, 2'd3, 3'd3, 4'd2, 7'd8);
    vDeliver = 8'h20;
    probe(1'b1, 8'h20, "R10 second link from V5");
  endtask

  task automatic t_reset_clears();
    do_reset();
    drive(8'h00, 8'h00, 8'h00, 2'd1, 3'd0, 4'd3, 7'd4);
    probe(1'b1, 8'h00, "R1 reserve A0");
    drive(8'h01, 8'h00, 8'h00, 2'd0, 3'd0, 4'd1, 7'd4);
    probe(1'b0, 8'h00, "R1 A0 held");
    do_reset();
    drive(8'h01, 8'h00, 8'h00, 2'd0, 3'd0, 4'd1, 7'd4);
    probe(1'b1, 8'h00, "R1 reset cleared A0");
  endtask

  initial begin
    idle();
    vecLen = 7'd4;
    t_reset();
    t_addr_resv();
    t_scal_resv();
    t_addr_port();
    t_scal_port();
    t_vector();
    t_chain();
    t_reset_clears();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule